// File: doc/BRIEF.md
# Daisy-Chained Bus Arbiter

This block decides which of several DMA-style masters takes the shared system bus from the processor. All masters share one request line. The processor answers that line with one grant, and the grant passes down a chain of per-device cells. The first cell that holds a pending request keeps the grant and does not pass it on. Every other cell passes it on in the same cycle. A shared busy line shows that a device currently owns the bus. A device takes the bus only when that line is free. The processor takes the grant back as soon as the new owner drives busy. When the owner lets go of busy, the bus returns to the processor, unless the request line is still active. In that case a new grant goes out straight away.

The processor side is a three-state machine. HOST_OWN means the processor is master. It moves to HOST_GRANT when the request line is up and the processor's current bus cycle has finished. HOST_GRANT drives the grant into the chain and moves to HOST_AWAY when busy rises. HOST_AWAY waits for busy to fall. It then goes back to HOST_GRANT if a request is pending and to HOST_OWN if not. Each chain cell has its own three-state machine. CELL_IDLE passes the grant on and moves to CELL_WAIT when its device requests. CELL_WAIT drives the request line, keeps any arriving grant, and moves to CELL_OWN when the grant is present and busy is free. CELL_OWN drives busy, no longer drives the request, and returns to CELL_IDLE when its device signals that it is done.

Priority is fixed by position. Cell 0 is nearest the processor and wins over every cell further down.

Top module: `dca_arbiter`

## Requirements
- R1: After reset, no grant is driven into the chain, no device drives busy, the request line is low and `cpu_owner` is 1.
- R2: `bus_req` is high from the cycle after a device request is registered until that device takes busy. It stays high while any other request is still pending.
- R3: `grant_chain[0]` rises only one cycle after an edge where `bus_req` and `cpu_cycle_done` are both high while the processor is master. While `cpu_cycle_done` is low, no grant is issued.
- R4: A cell in CELL_IDLE passes its incoming grant to the next cell in the same cycle. A cell in CELL_WAIT keeps the grant, so that every later `grant_chain` bit and `grant_exit` are low.
- R5: A cell that holds the grant while busy is free drives busy from the next edge. From that same edge it no longer drives `bus_req`.
- R6: `grant_chain[0]` falls at the edge after `bus_busy` rises, and `cpu_owner` is 0 from that edge.
- R7: After the owning device pulses `dev_done`, `bus_busy` falls at the next edge. One edge later, `cpu_owner` returns to 1 if no request is pending. If a request is pending, a new grant is issued instead.
- R8: When several devices request at the same time, the one with the lowest index takes the bus first. The others are served after it, in order.
- R9: At most one bit of `dev_busy` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cycle_done | input | 1 | Processor has finished its current bus cycle |
| dev_req | input | N_DEV | Request from each device, registered by its cell |
| dev_done | input | N_DEV | Pulse from the owning device to release the bus |
| grant_chain | output | N_DEV | Grant arriving at each cell; bit 0 comes from the processor |
| grant_exit | output | 1 | Grant passed on by the last cell |
| bus_req | output | 1 | Shared request line, OR of the pending cells |
| bus_busy | output | 1 | Shared busy line, OR of `dev_busy` |
| dev_busy | output | N_DEV | Busy driven by each cell |
| cpu_owner | output | 1 | Processor is bus master |

## Verification
A cell whose state machine goes wrong shows up at the ports within one or two cycles. A cell stuck in CELL_WAIT keeps the grant and cuts off every cell below it in the chain. A cell that passes the grant on while it is requesting lets a cell further down win, and the wrong `dev_busy` bit rises. A processor machine that never leaves HOST_GRANT keeps `grant_chain[0]` high after busy has risen. A machine that skips HOST_AWAY gives `cpu_owner` back while a device is still busy. The bench records, for each transfer, which device is expected to take busy. It then compares this with the bit that actually rises.

// File: rtl/dca_pkg.sv
`timescale 1ns/1ps
package dca_pkg;
    typedef enum logic [1:0] {
        CELL_IDLE = 2'd0,
        CELL_WAIT = 2'd1,
        CELL_OWN  = 2'd2
    } cell_state_e;

    typedef enum logic [1:0] {
        HOST_OWN   = 2'd0,
        HOST_GRANT = 2'd1,
        HOST_AWAY  = 2'd2
    } host_state_e;
endpackage

// File: rtl/dca_host_grant.sv
`timescale 1ns/1ps
module dca_host_grant
    import dca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req_i,
    input  logic cycle_done_i,
    input  logic bus_busy_i,
    output logic grant_o,
    output logic owner_o
);
    host_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOST_OWN:   if (bus_req_i && cycle_done_i) state_d = HOST_GRANT;
            HOST_GRANT: if (bus_busy_i) state_d = HOST_AWAY;
            HOST_AWAY:  if (!bus_busy_i) state_d = bus_req_i ? HOST_GRANT : HOST_OWN;
            default:    state_d = HOST_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HOST_OWN;
        else        state_q <= state_d;
    end

    always_comb begin
        grant_o = (state_q == HOST_GRANT);
        owner_o = (state_q == HOST_OWN);
    end

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> $past(bus_req_i)); // R3
    AST_GRANT_WITHDRAWN: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && bus_busy_i) |=> !grant_o && !owner_o); // R6
    AST_RETURN_TO_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HOST_AWAY && !bus_busy_i && !bus_req_i) |=> owner_o); // R7
endmodule

// File: rtl/dca_chain_cell.sv
`timescale 1ns/1ps
module dca_chain_cell
    import dca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic done_i,
    input  logic grant_i,
    input  logic bus_busy_i,
    output logic grant_o,
    output logic br_o,
    output logic busy_o
);
    cell_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE: if (req_i) state_d = CELL_WAIT;
            CELL_WAIT: if (grant_i && !bus_busy_i) state_d = CELL_OWN;
            CELL_OWN:  if (done_i) state_d = CELL_IDLE;
            default:   state_d = CELL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CELL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        grant_o = grant_i && (state_q == CELL_IDLE);
        br_o    = (state_q == CELL_WAIT);
        busy_o  = (state_q == CELL_OWN);
    end

    AST_TAKE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(grant_i) && !$past(bus_busy_i)); // R5
    AST_ABSORB_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (br_o && grant_i && !bus_busy_i) |=> busy_o && !br_o); // R5
endmodule

// File: rtl/dca_arbiter.sv
`timescale 1ns/1ps
module dca_arbiter #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_cycle_done,
    input  logic [N_DEV-1:0] dev_req,
    input  logic [N_DEV-1:0] dev_done,
    output logic [N_DEV-1:0] grant_chain,
    output logic             grant_exit,
    output logic             bus_req,
    output logic             bus_busy,
    output logic [N_DEV-1:0] dev_busy,
    output logic             cpu_owner
);
    localparam int LINKS = N_DEV + 1;

    logic [LINKS-1:0] link;
    logic [N_DEV-1:0] br_vec;
    logic             host_grant;

    dca_host_grant u_host (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req_i    (bus_req),
        .cycle_done_i (cpu_cycle_done),
        .bus_busy_i   (bus_busy),
        .grant_o      (host_grant),
        .owner_o      (cpu_owner)
    );

    assign link[0] = host_grant;

    for (genvar k = 0; k < N_DEV; k++) begin : g_cell
        dca_chain_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (dev_req[k]),
            .done_i     (dev_done[k]),
            .grant_i    (link[k]),
            .bus_busy_i (bus_busy),
            .grant_o    (link[k+1]),
            .br_o       (br_vec[k]),
            .busy_o     (dev_busy[k])
        );
    end

    assign grant_chain = link[N_DEV-1:0];
    assign grant_exit  = link[N_DEV];
    assign bus_req     = |br_vec;
    assign bus_busy    = |dev_busy;

    AST_ONE_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dev_busy) <= 1); // R9
    AST_HOST_NOT_WITH_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |-> !cpu_owner); // R6
endmodule

// File: tb/dca_arbiter_test.sv
`timescale 1ns/1ps
module dca_arbiter_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_cycle_done = 1'b1;
    logic [N-1:0] dev_req = '0;
    logic [N-1:0] dev_done = '0;
    logic [N-1:0] grant_chain;
    logic         grant_exit;
    logic         bus_req;
    logic         bus_busy;
    logic [N-1:0] dev_busy;
    logic         cpu_owner;

    int checks = 0;
    int fails = 0;
    int exp_q[$];
    logic prev_busy = 1'b0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    dca_arbiter #(.N_DEV(N)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_cycle_done(cpu_cycle_done),
        .dev_req(dev_req), .dev_done(dev_done), .grant_chain(grant_chain),
        .grant_exit(grant_exit), .bus_req(bus_req), .bus_busy(bus_busy),
        .dev_busy(dev_busy), .cpu_owner(cpu_owner)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver side of the scoreboard: the device expected to take busy next
    task automatic expect_owner(input int idx);
        exp_q.push_back(idx);
    endtask

    // monitor: on every rise of busy, compare the owner with the queue (R8, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if ($countones(dev_busy) > 1) begin
                fails++;
                $display("FAIL R9: actual %b expected at most one bit", dev_busy);
            end
            if (bus_busy && !prev_busy) begin
                int got;
                got = -1;
                for (int i = 0; i < N; i++) if (dev_busy[i]) got = i;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R8: actual owner %0d expected none", got);
                end else begin
                    int want;
                    want = exp_q.pop_front();
                    if (got != want) begin
                        fails++;
                        $display("FAIL R8: actual owner %0d expected %0d", got, want);
                    end
                end
            end
        end
        prev_busy <= bus_busy;
    end

    initial begin
        #(200000 * 4);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 grant", grant_chain, 0);
        chk("R1 busy", dev_busy, 0);
        chk("R1 bus_req", bus_req, 0);
        chk("R1 cpu_owner", cpu_owner, 1);

        // single request from device 2
        dev_req = 4'b0100; expect_owner(2);
        tick(1);
        chk("R2 bus_req up", bus_req, 1);
        chk("R3 no grant yet", grant_chain, 0);
        tick(1);
        chk("R4 forward then absorb", grant_chain, 4'b0111);
        chk("R4 exit", grant_exit, 0);
        tick(1);
        chk("R5 busy taken", dev_busy, 4'b0100);
        chk("R5 request dropped", bus_req, 0);
        dev_req = '0;
        tick(1);
        chk("R6 grant withdrawn", grant_chain, 0);
        chk("R6 cpu not owner", cpu_owner, 0);
        dev_done = 4'b0100;
        tick(1);
        dev_done = '0;
        chk("R7 busy released", bus_busy, 0);
        chk("R7 still away", cpu_owner, 0);
        tick(1);
        chk("R7 cpu regains", cpu_owner, 1);

        // processor still in a bus cycle
        cpu_cycle_done = 1'b0;
        dev_req = 4'b0010; expect_owner(1);
        tick(4);
        chk("R3 held off", grant_chain, 0);
        chk("R2 pending", bus_req, 1);
        cpu_cycle_done = 1'b1;
        dev_req = '0;
        tick(1);
        chk("R3 grant issued", grant_chain, 4'b0011);
        tick(1);
        chk("R5 device1 busy", dev_busy, 4'b0010);
        tick(1);
        dev_done = 4'b0010;
        tick(1);
        dev_done = '0;
        tick(1);
        chk("R7 cpu back", cpu_owner, 1);

        // simultaneous requests: device 1 before device 3
        dev_req = 4'b1010; expect_owner(1); expect_owner(3);
        tick(1);
        chk("R2 both pending", bus_req, 1);
        tick(1);
        chk("R8 nearest absorbs", grant_chain, 4'b0011);
        dev_req = '0;
        tick(1);
        chk("R8 device1 first", dev_busy, 4'b0010);
        chk("R2 other still pending", bus_req, 1);
        tick(1);
        dev_done = 4'b0010;
        tick(1);
        dev_done = '0;
        chk("R7 released", bus_busy, 0);
        tick(1);
        chk("R7 regrant not cpu", cpu_owner, 0);
        chk("R4 forward to device3", grant_chain, 4'b1111);
        chk("R4 exit blocked", grant_exit, 0);
        tick(1);
        chk("R8 device3 second", dev_busy, 4'b1000);
        tick(1);
        dev_done = 4'b1000;
        tick(1);
        dev_done = '0;
        tick(1);
        chk("R7 final cpu owner", cpu_owner, 1);
        chk("R8 queue drained", exp_q.size(), 0);

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule